// File: doc/BRIEF.md
# Sign-Sequence CORDIC Rotator Pair

This block is an iterative fixed-point two-dimensional CORDIC engine that never forms an angle. A rotation is carried only as a string of direction bits, one per micro-rotation. In a vectoring operation the engine turns a primary vector until its second component settles at zero. It records the direction chosen at each step. In the same cycle it applies that direction to a companion vector, so the companion undergoes the identical rotation. In a replay operation a direction string captured earlier is loaded and applied to both vectors, which reproduces the same rotation on new data.

Three coordinate systems are available. Circular mode rotates. Linear mode performs non-restoring division of the primary second component by the primary first component, and the same bits accumulate a scaled product on the companion vector. Hyperbolic mode drives the second component to zero, which leaves a value of the form sqrt(x² − y²) in the first component. The engine completes one micro-rotation per clock. The scaling gain of the circular and hyperbolic modes is left in the results for the surrounding datapath to absorb.

Inputs have W bits in two's complement: one sign bit, one integer bit and W−2 fraction bits. The registers and outputs are W+2 bits wide, with the same binary point and two extra integer guard bits. Each micro-rotation uses an arithmetic right shift, which rounds toward minus infinity.

Top module: `cordic_sp_pair`

## Requirements
- R1: In circular vectoring with W=16, the four outputs equal 16 micro-rotations with shift indices 0 to 15, applied to both vectors. Each step computes x' = x − s·(y>>>i) and y' = y + s·(x>>>i). The direction s is +1 when the primary y is negative before the step and −1 otherwise. The gain is not corrected, and the primary y ends within 32 LSB of zero.
- R2: In vectoring, bit k of sign_o is 1 exactly when step k used s = +1, that is, when the primary y was negative before that step. Bits beyond the last step read 0.
- R3: The companion vector receives the same direction in the same step as the primary vector. Replaying the captured bits on the companion inputs therefore gives the same companion result as the vectoring run.
- R4: In a replay operation (op = 1), step k takes s = +1 when sign_i bit k is 1 and s = −1 when it is 0. The bits are applied to both vectors, and sign_o shows the loaded bits unchanged.
- R5: In linear mode (mode = 1) the primary x never changes. Each step computes y' = y + s·(x>>>i) and v' = v + s·(u>>>i), with shifts 0 to W−1. The companion second component ends near v − u·y/x.
- R6: In hyperbolic mode (mode = 2) the shifts run 1, 2, 3, 4, 4, 5, …, 13, 13, 14, … up to W−1, which is 17 steps for W=16. Each step computes x' = x + s·(y>>>i) and y' = y + s·(x>>>i). Mode 0 is circular; mode 3 is handled as circular.
- R7: done is high for exactly one cycle. It is high in the cycle that follows the N-th clock edge after the edge that accepts start, where N is 16 for circular and linear and 17 for hyperbolic at W=16.
- R8: A start pulse that arrives while busy is high is ignored. The running operation completes with its original result.
- R9: While the engine is idle and start is low, sign_o and the vector outputs hold their values, whatever happens on the data inputs.
- R10: After reset, busy, done, sign_o and all vector outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; taken only while idle |
| mode | input | 2 | 0 circular, 1 linear, 2 hyperbolic, 3 circular |
| op | input | 1 | 0 vectoring, 1 replay |
| px_i | input | W | Primary vector first component |
| py_i | input | W | Primary vector second component |
| cx_i | input | W | Companion vector first component |
| cy_i | input | W | Companion vector second component |
| sign_i | input | W+1 | Direction bits to replay, bit k for step k |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| px_o | output | W+2 | Primary first component result |
| py_o | output | W+2 | Primary second component result |
| cx_o | output | W+2 | Companion first component result |
| cy_o | output | W+2 | Companion second component result |
| sign_o | output | W+1 | Captured or loaded direction bits |

## Verification
The hardest behaviour to reach from the ports is the lockstep use of one direction on two vectors. A wrong companion update can still look plausible. To expose it, the stimulus runs a vectoring operation and then feeds the captured bits back through replay, with the two vectors swapped. Each vector must then reproduce the other's earlier result bit for bit. The repeated hyperbolic shift indices are reached only by running the full hyperbolic sequence, so they are checked through the exact results and the 17-cycle latency. A start pulse is also injected in the middle of a run, together with changed data, to show that the active operation is not disturbed.

// File: rtl/cordic_sp_pkg.sv
package cordic_sp_pkg;

  typedef enum logic [1:0] {
    MODE_CIRC = 2'd0,
    MODE_LIN  = 2'd1,
    MODE_HYP  = 2'd2,
    MODE_ALT  = 2'd3
  } mode_e;

  typedef enum logic {
    OP_VECTOR = 1'b0,
    OP_REPLAY = 1'b1
  } op_e;

  // Shift index used at step k; hyperbolic repeats 4 and 13 for convergence.
  function automatic int step_shift(mode_e m, int k);
    int s;
    s = k;
    if (m == MODE_HYP) begin
      s = k + 1;
      if (k >= 4)  s = s - 1;
      if (k >= 14) s = s - 1;
    end
    return s;
  endfunction

  // Number of micro-rotations for a given data width.
  function automatic int step_total(mode_e m, int w);
    int n;
    n = w;
    if (m == MODE_HYP) begin
      n = w - 1;
      if (w - 1 >= 4)  n = n + 1;
      if (w - 1 >= 13) n = n + 1;
    end
    return n;
  endfunction

endpackage

// File: rtl/cordic_sp_ctrl.sv
module cordic_sp_ctrl
  import cordic_sp_pkg::*;
#(
  parameter int W  = 16,
  parameter int KW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  mode_e         mode_q,
  output logic          busy,
  output logic          load,
  output logic          last_step,
  output logic          done,
  output logic [KW-1:0] k
);

  logic [KW-1:0] k_last;

  assign k_last    = KW'(step_total(mode_q, W) - 1);
  assign load      = start & ~busy;
  assign last_step = busy & (k == k_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      k    <= '0;
      done <= 1'b0;
    end else begin
      done <= last_step;
      if (load) begin
        busy <= 1'b1;
        k    <= '0;
      end else if (busy) begin
        if (last_step) busy <= 1'b0;
        else           k    <= k + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cordic_sp_stage.sv
module cordic_sp_stage
  import cordic_sp_pkg::*;
#(
  parameter int IW = 18,
  parameter int KW = 5
) (
  input  mode_e                 mode,
  input  logic                  dir_pos,
  input  logic [KW-1:0]         shamt,
  input  logic signed [IW-1:0]  a_i,
  input  logic signed [IW-1:0]  b_i,
  output logic signed [IW-1:0]  a_o,
  output logic signed [IW-1:0]  b_o
);

  // One micro-rotation of (a, b) in the chosen coordinate system.
  function automatic void micro(input mode_e m, input logic pos,
                                input logic [KW-1:0] sh,
                                input logic signed [IW-1:0] a,
                                input logic signed [IW-1:0] b,
                                output logic signed [IW-1:0] na,
                                output logic signed [IW-1:0] nb);
    logic signed [IW-1:0] sa;
    logic signed [IW-1:0] sb;
    sa = a >>> sh;
    sb = b >>> sh;
    nb = pos ? (b + sa) : (b - sa);
    case (m)
      MODE_LIN: na = a;
      MODE_HYP: na = pos ? (a + sb) : (a - sb);
      default:  na = pos ? (a - sb) : (a + sb);
    endcase
  endfunction

  always_comb begin
    micro(mode, dir_pos, shamt, a_i, b_i, a_o, b_o);
  end

endmodule

// File: rtl/cordic_sp_signs.sv
module cordic_sp_signs #(
  parameter int NS = 17,
  parameter int KW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NS-1:0] load_val,
  input  logic          wr_en,
  input  logic [KW-1:0] idx,
  input  logic          bit_val,
  output logic [NS-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q      <= '0;
    else if (load)  q      <= load_val;
    else if (wr_en) q[idx] <= bit_val;
  end

endmodule

// File: rtl/cordic_sp_pair.sv
module cordic_sp_pair
  import cordic_sp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [1:0]            mode,
  input  logic                  op,
  input  logic signed [W-1:0]   px_i,
  input  logic signed [W-1:0]   py_i,
  input  logic signed [W-1:0]   cx_i,
  input  logic signed [W-1:0]   cy_i,
  input  logic [W:0]            sign_i,
  output logic                  busy,
  output logic                  done,
  output logic signed [W+1:0]   px_o,
  output logic signed [W+1:0]   py_o,
  output logic signed [W+1:0]   cx_o,
  output logic signed [W+1:0]   cy_o,
  output logic [W:0]            sign_o
);

  localparam int IW = W + 2;
  localparam int NS = W + 1;
  localparam int KW = $clog2(NS + 1);

  mode_e                mode_q;
  op_e                  op_q;
  logic signed [IW-1:0] vx_q [2];
  logic signed [IW-1:0] vy_q [2];
  logic signed [IW-1:0] x_in [2];
  logic signed [IW-1:0] y_in [2];
  logic signed [IW-1:0] nx   [2];
  logic signed [IW-1:0] ny   [2];

  // Named internal events for the checker.
  logic          load_w;
  logic          last_w;
  logic [KW-1:0] k_w;
  logic          y_neg_w;
  logic          dir_pos_w;
  logic [KW-1:0] shamt_w;
  logic [NS-1:0] sign_q;

  assign x_in[0] = IW'(px_i);
  assign y_in[0] = IW'(py_i);
  assign x_in[1] = IW'(cx_i);
  assign y_in[1] = IW'(cy_i);

  cordic_sp_ctrl #(.W(W), .KW(KW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode_q    (mode_q),
    .busy      (busy),
    .load      (load_w),
    .last_step (last_w),
    .done      (done),
    .k         (k_w)
  );

  assign y_neg_w   = vy_q[0][IW-1];
  assign dir_pos_w = (op_q == OP_REPLAY) ? sign_q[k_w] : y_neg_w;
  assign shamt_w   = KW'(step_shift(mode_q, int'(k_w)));

  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      cordic_sp_stage #(.IW(IW), .KW(KW)) u_stage (
        .mode    (mode_q),
        .dir_pos (dir_pos_w),
        .shamt   (shamt_w),
        .a_i     (vx_q[g]),
        .b_i     (vy_q[g]),
        .a_o     (nx[g]),
        .b_o     (ny[g])
      );
    end
  endgenerate

  cordic_sp_signs #(.NS(NS), .KW(KW)) u_signs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_w),
    .load_val (op ? sign_i : '0),
    .wr_en    (busy & (op_q == OP_VECTOR)),
    .idx      (k_w),
    .bit_val  (y_neg_w),
    .q        (sign_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CIRC;
      op_q   <= OP_VECTOR;
      for (int g = 0; g < 2; g++) begin
        vx_q[g] <= '0;
        vy_q[g] <= '0;
      end
    end else if (load_w) begin
      mode_q <= mode_e'(mode);
      op_q   <= op_e'(op);
      for (int g = 0; g < 2; g++) begin
        vx_q[g] <= x_in[g];
        vy_q[g] <= y_in[g];
      end
    end else if (busy) begin
      for (int g = 0; g < 2; g++) begin
        vx_q[g] <= nx[g];
        vy_q[g] <= ny[g];
      end
    end
  end

  assign px_o   = vx_q[0];
  assign py_o   = vy_q[0];
  assign cx_o   = vx_q[1];
  assign cy_o   = vy_q[1];
  assign sign_o = sign_q;

endmodule

// File: rtl/cordic_sp_pair_chk.sv
module cordic_sp_pair_chk #(
  parameter int W  = 16,
  parameter int NS = 17,
  parameter int KW = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 load,
  input logic                 done,
  input logic                 last_step,
  input logic [KW-1:0]        k,
  input logic                 op_q,
  input logic [1:0]           mode_q,
  input logic                 y_neg,
  input logic [NS-1:0]        sign_o,
  input logic signed [W+1:0]  px_o
);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done);

  assert_busy_continues_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> (busy && k == $past(k) + 1'b1));

  assert_no_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load);

  assert_sign_record_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_q) |=> (sign_o[$past(k)] == $past(y_neg)));

  assert_sign_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sign_o) && $stable(px_o)));

  assert_linear_x_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q == 2'd1) |=> $stable(px_o));

endmodule

bind cordic_sp_pair cordic_sp_pair_chk #(.W(W), .NS(NS), .KW(KW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .load      (load_w),
  .done      (done),
  .last_step (last_w),
  .k         (k_w),
  .op_q      (op_q),
  .mode_q    (mode_q),
  .y_neg     (y_neg_w),
  .sign_o    (sign_o),
  .px_o      (px_o)
);

// File: tb/cordic_sp_pair_bench.sv
module cordic_sp_pair_bench;

  localparam int W  = 16;
  localparam int NS = W + 1;
  localparam int IW = W + 2;
  localparam real SC = 16384.0;

  typedef struct packed {
    int md; int x; int y; int u; int v;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{0,  9830,  11469,  8192, -4096},
    '{0, 14746, -13107, -4915,  9830},
    '{0,  3277,      0, 16384,     0},
    '{1, 13107,  -6554,  8192,  1638},
    '{1,  8192,  11469, -9830,  3277},
    '{2, 16384,   9830,  8192,  4915},
    '{2, 14746,  -8192,  3277, -1638}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic op = 1'b0;
  logic signed [W-1:0] px_i = '0, py_i = '0, cx_i = '0, cy_i = '0;
  logic [NS-1:0] sign_i = '0;
  logic busy, done;
  logic signed [IW-1:0] px_o, py_o, cx_o, cy_o;
  logic [NS-1:0] sign_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cordic_sp_pair #(.W(W)) u_cordic_sp_pair (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .op(op),
    .px_i(px_i), .py_i(py_i), .cx_i(cx_i), .cy_i(cy_i), .sign_i(sign_i),
    .busy(busy), .done(done), .px_o(px_o), .py_o(py_o), .cx_o(cx_o),
    .cy_o(cy_o), .sign_o(sign_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_real(input string tag, input real act, input real exp, input real tol);
    real d;
    d = act - exp;
    if (d < 0.0) d = -d;
    checks++;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual=%f expected=%f", tag, act, exp);
    end
  endtask

  // Independent reference: shift list built by walking indices, one loop of steps.
  task automatic model(input int md, input bit rep, input longint x0, input longint y0,
                       input longint u0, input longint v0, input logic [NS-1:0] sin,
                       output longint xo, output longint yo, output longint uo,
                       output longint vo, output logic [NS-1:0] so, output int n);
    int shl [NS];
    int idx;
    longint x, y, u, v, xn, yn, un, vn, mm, s;
    n = 0;
    if (md == 2) begin
      idx = 1;
      while (idx <= W - 1 && n < NS) begin
        shl[n] = idx; n++;
        if ((idx == 4 || idx == 13) && n < NS) begin shl[n] = idx; n++; end
        idx++;
      end
    end else begin
      for (int i = 0; i < W; i++) begin shl[n] = i; n++; end
    end
    mm = (md == 2) ? -1 : ((md == 1) ? 0 : 1);
    x = x0; y = y0; u = u0; v = v0;
    so = rep ? sin : '0;
    for (int j = 0; j < n; j++) begin
      if (rep) s = sin[j] ? 1 : -1;
      else begin
        s = (y < 0) ? 1 : -1;
        so[j] = (s > 0);
      end
      xn = x - mm * s * (y >>> shl[j]);
      yn = y + s * (x >>> shl[j]);
      un = u - mm * s * (v >>> shl[j]);
      vn = v + s * (u >>> shl[j]);
      x = xn; y = yn; u = un; v = vn;
    end
    xo = x; yo = y; uo = u; vo = v;
  endtask

  // Launch one operation; returns edges from acceptance to done.
  task automatic run(input int md, input bit rep, input int x, input int y, input int u,
                     input int v, input logic [NS-1:0] sin, input bit disturb,
                     output int lat);
    int cyc;
    @(negedge clk);
    mode = md[1:0]; op = rep;
    px_i = W'(x); py_i = W'(y); cx_i = W'(u); cy_i = W'(v); sign_i = sin;
    start = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      start = (disturb && cyc == 3);
      if (start) begin px_i = 16'sd1000; py_i = -16'sd2000; mode = 2'd1; op = 1'b1; end
    end while (!done && cyc < 100);
    lat = cyc - 1;
  endtask

  real kc, kh;

  initial begin : main
    longint ex, ey, eu, ev;
    logic [NS-1:0] es;
    int en, lat;
    longint sx, sy, su, sv;
    logic [NS-1:0] ss;
    string rq;

    kc = 1.0;
    for (int i = 0; i < W; i++) kc = kc * $sqrt(1.0 + 1.0 / (4.0 ** i));
    kh = 1.0;
    for (int i = 1; i < W; i++) begin
      kh = kh * $sqrt(1.0 - 1.0 / (4.0 ** i));
      if (i == 4 || i == 13) kh = kh * $sqrt(1.0 - 1.0 / (4.0 ** i));
    end

    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0 && done == 1'b0, "R10 busy/done", {busy, done}, 0);
    check(sign_o == '0, "R10 sign_o", sign_o, 0);
    check(px_o == 0 && py_o == 0 && cx_o == 0 && cy_o == 0, "R10 vectors", px_o, 0);
    rst_n = 1'b1;

    for (int t = 0; t < NV; t++) begin
      vec_t e;
      e = TBL[t];
      rq = (e.md == 0) ? "R1" : ((e.md == 1) ? "R5" : "R6");
      run(e.md, 1'b0, e.x, e.y, e.u, e.v, '0, (t == 1), lat);
      model(e.md, 1'b0, e.x, e.y, e.u, e.v, '0, ex, ey, eu, ev, es, en);
      if (t == 1) rq = "R8";
      check(longint'(px_o) == ex, {rq, " px_o"}, px_o, ex);
      check(longint'(py_o) == ey, {rq, " py_o"}, py_o, ey);
      check(longint'(cx_o) == eu, {rq, " cx_o"}, cx_o, eu);
      check(longint'(cy_o) == ev, {rq, " cy_o"}, cy_o, ev);
      check(sign_o == es, "R2 sign_o", sign_o, es);
      check(lat == en, "R7 latency", lat, en);
      if (e.md == 2) check(lat == 17, "R6 hyperbolic step count", lat, 17);
      @(negedge clk);
      check(done == 1'b0, "R7 done one cycle", done, 0);
      if (e.md == 0) begin
        check_real("R1 gain magnitude", real'(px_o) / SC,
                   kc * $sqrt((e.x * 1.0) ** 2 + (e.y * 1.0) ** 2) / SC, 0.004);
        check(py_o < 32 && py_o > -32, "R1 residual y", py_o, 0);
      end else if (e.md == 1) begin
        check_real("R5 product", real'(cy_o) / SC,
                   (e.v - e.u * (e.y * 1.0) / e.x) / SC, 0.004);
      end else begin
        check_real("R6 magnitude", real'(px_o) / SC,
                   kh * $sqrt((e.x * 1.0) ** 2 - (e.y * 1.0) ** 2) / SC, 0.004);
      end

      if (t == 0 || t == 5) begin
        sx = px_o; sy = py_o; su = cx_o; sv = cy_o; ss = sign_o;
        run(e.md, 1'b1, e.u, e.v, e.x, e.y, ss, 1'b0, lat);
        check(longint'(px_o) == su && longint'(py_o) == sv, "R3 companion replay", px_o, su);
        check(longint'(cx_o) == sx && longint'(cy_o) == sy, "R4 replay primary", cx_o, sx);
        check(sign_o == ss, "R4 loaded bits kept", sign_o, ss);
      end
    end

    // R4: replay of an arbitrary pattern against the reference
    run(0, 1'b1, 5000, -3000, 7000, 2000, 17'h0A5C3, 1'b0, lat);
    model(0, 1'b1, 5000, -3000, 7000, 2000, 17'h0A5C3, ex, ey, eu, ev, es, en);
    check(longint'(px_o) == ex && longint'(py_o) == ey, "R4 pattern primary", px_o, ex);
    check(longint'(cx_o) == eu && longint'(cy_o) == ev, "R4 pattern companion", cx_o, eu);

    // R9: idle outputs hold while data inputs move
    sx = px_o; ss = sign_o;
    @(negedge clk);
    px_i = 16'sd123; py_i = -16'sd456; sign_i = '1; op = 1'b0; mode = 2'd2;
    repeat (6) @(negedge clk);
    check(sign_o == ss, "R9 sign_o hold", sign_o, ss);
    check(longint'(px_o) == sx && busy == 1'b0, "R9 px_o hold", px_o, sx);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule